// File: doc/BRIEF.md
# Dual-Tone Frequency Counting Decoder

This block recognises telephone dual-tone digits from two square waves that an analog front end has already band-split and hard-limited. One input carries the low-group tone and the other the high-group tone. Each input is resynchronised to the reference clock. The block then measures the time between successive rising edges in reference-clock cycles and sorts each measurement into one of four frequency bins for its band.

A band counts as holding a tone only after several periods in a row land in the same bin. Isolated periods and speech that wanders between frequencies therefore do not produce a digit. While both bands hold a tone, the block raises an early-steering flag and presents a 4-bit digit code. A later guard-time stage decides whether the digit lasted long enough to be registered.

Top module: `dtmf_tone_decoder`

## Requirements
- R1: During and directly after reset, `est` is 0 and `code` is 4'b0000.
- R2: Each band measures one period as the number of reference-clock cycles between consecutive synchronized rising edges. A nominal count is round(CLK_HZ / f) for the low tones 697, 770, 852 and 941 Hz and for the high tones 1209, 1336, 1477 and 1633 Hz.
- R3: A period is classified as a tone when it lies within ±TOL_PERMIL/1000 (default 3%) of that tone's nominal count. A tone driven within ±2.5% of its frequency is accepted. A tone driven 4% to 6% off its frequency is rejected.
- R4: A band becomes valid only after AGREE_N (default 4) consecutive measured periods fall in the same bin. A period in a different bin restarts the run at one, and an unclassified period restarts it at zero. A wave whose period alternates between two bins never becomes valid.
- R5: `est` is 1 while both bands are valid and 0 as soon as either band is not.
- R6: Code mapping (code written as 4 bits, MSB first), rows by low tone and columns by high tone. The rows 697/770/852 Hz with 1209/1336/1477 Hz give 1..9 in row order (0001..1001). 941 Hz gives 1011 with 1209 Hz, 1010 with 1336 Hz and 1100 with 1477 Hz. 1633 Hz gives 1101, 1110, 1111 and 0000 with 697, 770, 852 and 941 Hz.
- R7: While `est` is 0, `code` keeps the last value presented while `est` was 1.
- R8: If a band sees no rising edge for 2·round(CLK_HZ/697) cycles, that band becomes invalid and `est` goes to 0. Tones that come back are decoded again.
- R9: Each input passes through a two-flop synchronizer, and a rising edge is a one-cycle pulse taken after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (CLK_HZ) |
| rst_n | input | 1 | Synchronous active-low reset |
| tone_lo | input | 1 | Limited low-group square wave, asynchronous |
| tone_hi | input | 1 | Limited high-group square wave, asynchronous |
| est | output | 1 | Early steering: both bands hold a valid tone |
| code | output | 4 | Digit code of the current or last tone pair |

## Verification
A wrong bin limit or an agreement counter stuck in a bin shows up at the ports as a wrong `est` level. The error appears a few tone periods after the input settles, either as a missing flag for an in-tolerance tone or as a flag for a tone that is off by 4% or more. A corrupted code mapping shows as a wrong `code` two cycles after the last agreeing edge. A broken timeout leaves `est` high well beyond twice the longest period after a band goes silent. The random pairs and deviations cover every code cell and both sides of the tolerance window. Directed cases cover alternating periods, silence and recovery.

// File: rtl/dtmf_pkg.sv
// Package: shared tone tables and code mapping for the tone decoder.
// Assumes tone index 0..3 runs from lowest to highest frequency in each band.
package dtmf_pkg;
    localparam int NTONES = 4;

    // Return the frequency in Hz of tone idx of a band (0 = low, 1 = high).
    function automatic int tone_hz(input int band, input int idx);
        int lo_t[4] = '{697, 770, 852, 941};
        int hi_t[4] = '{1209, 1336, 1477, 1633};
        return (band == 0) ? lo_t[idx] : hi_t[idx];
    endfunction

    // Return the rounded nominal period in reference-clock cycles.
    function automatic int nom_period(input int clk_hz, input int f_hz);
        return (clk_hz + f_hz / 2) / f_hz;
    endfunction

    // Map a (row, column) bin pair to the 4-bit digit code.
    function automatic logic [3:0] pair_code(input logic [1:0] row, input logic [1:0] col);
        logic [3:0] r;
        if (col == 2'd3) begin
            r = (row == 2'd3) ? 4'd0 : 4'd13 + {2'b00, row};
        end else if (row != 2'd3) begin
            r = 4'd3 * {2'b00, row} + {2'b00, col} + 4'd1;
        end else begin
            case (col)
                2'd0:    r = 4'd11;
                2'd1:    r = 4'd10;
                default: r = 4'd12;
            endcase
        end
        return r;
    endfunction
endpackage

// File: rtl/dtmf_edge_sync.sv
// Module: two-flop synchronizer followed by a rising-edge detector.
// Assumes the input is asynchronous to clk. The edge pulse lasts one cycle.
module dtmf_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [2:0] shr;

    // Shift the input through two sync flops and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) shr <= 3'b000;
        else        shr <= {shr[1:0], din};
    end

    assign rise = shr[1] & ~shr[2];
endmodule

// File: rtl/dtmf_band_meter.sv
// Module: period meter and bin classifier for one tone band.
// Counts cycles between rise pulses and sorts each period into one of four
// bins. It declares the band valid after AGREE_N agreeing periods in a row.
// Assumes that the bin windows do not overlap, which holds for tolerances under 4%.
module dtmf_band_meter #(
    parameter int CLK_HZ     = 3579545,
    parameter int BAND       = 0,
    parameter int TOL_PERMIL = 30,
    parameter int AGREE_N    = 4,
    parameter int TIMEOUT    = 10272
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise,
    output logic       valid,
    output logic [1:0] bin
);
    import dtmf_pkg::*;

    localparam int CW = $clog2(TIMEOUT + 2);
    localparam int AW = $clog2(AGREE_N + 1);

    logic [CW-1:0] cnt;
    logic          armed;
    logic [AW-1:0] agree, agree_n;
    logic [1:0]    bin_n;
    logic [NTONES-1:0] hits;
    logic          hit_any;
    logic [1:0]    hit_idx;

    // Per-tone window comparators on the current period count.
    for (genvar i = 0; i < NTONES; i++) begin : g_win
        localparam int NOM = nom_period(CLK_HZ, tone_hz(BAND, i));
        localparam int LOL = NOM - (NOM * TOL_PERMIL) / 1000;
        localparam int HIL = NOM + (NOM * TOL_PERMIL) / 1000;
        assign hits[i] = (cnt >= CW'(LOL)) && (cnt <= CW'(HIL));
    end

    // Encode the single hit into a bin index.
    always_comb begin
        hit_any = |hits;
        hit_idx = 2'd0;
        for (int i = 0; i < NTONES; i++)
            if (hits[i]) hit_idx = 2'(i);
    end

    // Next agreement count and bin for an edge that closes a measured period.
    always_comb begin
        agree_n = agree;
        bin_n   = bin;
        if (rise && armed) begin
            if (!hit_any) begin
                agree_n = '0;
            end else if (hit_idx == bin && agree != '0) begin
                agree_n = (agree >= AW'(AGREE_N)) ? agree : agree + 1'b1;
            end else begin
                bin_n   = hit_idx;
                agree_n = AW'(1);
            end
        end
    end

    // Period counter, arming, timeout and validity state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            armed <= 1'b0;
            agree <= '0;
            bin   <= 2'd0;
            valid <= 1'b0;
        end else if (rise) begin
            cnt   <= CW'(1);
            armed <= 1'b1;
            agree <= agree_n;
            bin   <= bin_n;
            valid <= (agree_n >= AW'(AGREE_N));
        end else if (cnt >= CW'(TIMEOUT)) begin
            armed <= 1'b0;
            agree <= '0;
            valid <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dtmf_tone_decoder.sv
// Module: top of the dual-tone decoder. Two synchronized band meters feed a
// registered steering flag and a digit code.
// Assumes the inputs are hard-limited tone waves and clk runs at CLK_HZ.
module dtmf_tone_decoder #(
    parameter int CLK_HZ     = 3579545,
    parameter int TOL_PERMIL = 30,
    parameter int AGREE_N    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_lo,
    input  logic       tone_hi,
    output logic       est,
    output logic [3:0] code
);
    import dtmf_pkg::*;

    localparam int TIMEOUT = 2 * nom_period(CLK_HZ, 697);

    logic       lo_edge, hi_edge;
    logic       lo_valid, hi_valid;
    logic [1:0] lo_bin, hi_bin;

    dtmf_edge_sync u_sync_lo (.clk(clk), .rst_n(rst_n), .din(tone_lo), .rise(lo_edge));
    dtmf_edge_sync u_sync_hi (.clk(clk), .rst_n(rst_n), .din(tone_hi), .rise(hi_edge));

    dtmf_band_meter #(.CLK_HZ(CLK_HZ), .BAND(0), .TOL_PERMIL(TOL_PERMIL),
                      .AGREE_N(AGREE_N), .TIMEOUT(TIMEOUT))
        u_meter_lo (.clk(clk), .rst_n(rst_n), .rise(lo_edge), .valid(lo_valid), .bin(lo_bin));

    dtmf_band_meter #(.CLK_HZ(CLK_HZ), .BAND(1), .TOL_PERMIL(TOL_PERMIL),
                      .AGREE_N(AGREE_N), .TIMEOUT(TIMEOUT))
        u_meter_hi (.clk(clk), .rst_n(rst_n), .rise(hi_edge), .valid(hi_valid), .bin(hi_bin));

    // Register the steering flag, and load the code only while both bands are valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est  <= 1'b0;
            code <= 4'd0;
        end else begin
            est <= lo_valid & hi_valid;
            if (lo_valid && hi_valid) code <= pair_code(lo_bin, hi_bin);
        end
    end
endmodule

// File: rtl/dtmf_tone_decoder_chk.sv
// Checker: temporal properties of the tone decoder, bound into the top.
module dtmf_tone_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       est,
    input logic [3:0] code,
    input logic       lo_edge,
    input logic       hi_edge,
    input logic       lo_valid,
    input logic       hi_valid
);
    a_r7_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code) |-> est);

    a_r4_lo_valid_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_valid) |-> $past(lo_edge));

    a_r4_hi_valid_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hi_valid) |-> $past(hi_edge));

    a_r5_est_follows_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(est) |-> ($past(lo_edge, 2) || $past(hi_edge, 2)));

    a_r9_lo_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        lo_edge |=> !lo_edge);

    a_r9_hi_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        hi_edge |=> !hi_edge);
endmodule

bind dtmf_tone_decoder dtmf_tone_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .est(est), .code(code),
    .lo_edge(lo_edge), .hi_edge(hi_edge),
    .lo_valid(lo_valid), .hi_valid(hi_valid)
);

// File: tb/sim_dtmf_tone_decoder.sv
// Bench: square-wave tone pairs with random deviations plus directed cases.
module sim_dtmf_tone_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 357950;
    localparam int SETTLE     = 3600;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tone_lo = 1'b0, tone_hi = 1'b0;
    logic est;
    logic [3:0] code;

    int checks = 0, failures = 0;
    int lo_per = 0, hi_per = 0, lo_alt = 0;
    int lo_ph = 0, hi_ph = 0, lo_cur = 0;
    bit lo_sel = 1'b0;
    logic [3:0] last_code = 4'd0;
    bit done = 1'b0;

    dtmf_tone_decoder #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst_n(rst_n), .tone_lo(tone_lo), .tone_hi(tone_hi),
        .est(est), .code(code));

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Wave generators, updated away from the sampling edge.
    always @(negedge clk) begin
        if (lo_per == 0) begin
            tone_lo <= 1'b0; lo_ph <= 0; lo_cur <= 0;
        end else begin
            int cp;
            cp = (lo_cur == 0) ? lo_per : lo_cur;
            if (lo_ph >= cp - 1) begin
                lo_ph  <= 0;
                lo_sel <= ~lo_sel;
                lo_cur <= (lo_alt != 0 && !lo_sel) ? lo_alt : lo_per;
            end else lo_ph <= lo_ph + 1;
            tone_lo <= (lo_ph < cp / 2);
        end
        if (hi_per == 0) begin
            tone_hi <= 1'b0; hi_ph <= 0;
        end else begin
            if (hi_ph >= hi_per - 1) hi_ph <= 0;
            else hi_ph <= hi_ph + 1;
            tone_hi <= (hi_ph < hi_per / 2);
        end
    end

    function automatic int freq(input int band, input int idx);
        int l[4] = '{697, 770, 852, 941};
        int h[4] = '{1209, 1336, 1477, 1633};
        return band == 0 ? l[idx] : h[idx];
    endfunction

    function automatic int per_of(input int band, input int idx, input int dev_permil);
        real f;
        f = freq(band, idx) * (1000.0 + dev_permil) / 1000.0;
        return $rtoi(CLK_HZ / f + 0.5);
    endfunction

    function automatic logic [3:0] exp_code(input int r, input int c);
        logic [3:0] t[16] = '{4'b0001, 4'b0010, 4'b0011, 4'b1101,
                              4'b0100, 4'b0101, 4'b0110, 4'b1110,
                              4'b0111, 4'b1000, 4'b1001, 4'b1111,
                              4'b1011, 4'b1010, 4'b1100, 4'b0000};
        return t[r * 4 + c];
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_pair(input int r, input int c, input int dl, input int dh);
        lo_alt = 0;
        lo_per = per_of(0, r, dl);
        hi_per = per_of(1, c, dh);
        wait_cyc(SETTLE);
    endtask

    initial begin
        void'($urandom(32'd20240607));
        wait_cyc(4);
        check("R1 est", {4'd0, est}, 5'd0);
        check("R1 code", {1'b0, code}, 5'd0);
        rst_n = 1'b1;
        wait_cyc(2);
        check("R1 after release", {est, code}, 5'd0);

        // R6 exhaustive code table at nominal frequency
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++) begin
                drive_pair(r, c, 0, 0);
                check("R6 R2 R5 nominal pair", {est, code}, {1'b1, exp_code(r, c)});
                last_code = exp_code(r, c);
            end

        // R3 random pairs within tolerance, some pushed out of it
        for (int k = 0; k < 12; k++) begin
            int r, c, dl, dh;
            bit bad;
            r  = $urandom_range(0, 3);
            c  = $urandom_range(0, 3);
            dl = $urandom_range(0, 50) - 25;
            dh = $urandom_range(0, 50) - 25;
            bad = ($urandom_range(0, 2) == 0);
            if (bad) begin
                if ($urandom_range(0, 1) == 1) dl = ($urandom_range(0, 1) ? 1 : -1) * $urandom_range(40, 60);
                else                           dh = ($urandom_range(0, 1) ? 1 : -1) * $urandom_range(40, 60);
            end
            drive_pair(r, c, dl, dh);
            if (bad) check("R3 R7 out of tolerance rejected", {est, code}, {1'b0, last_code});
            else begin
                check("R3 in tolerance accepted", {est, code}, {1'b1, exp_code(r, c)});
                last_code = exp_code(r, c);
            end
        end

        // R3 directed edges of window
        drive_pair(1, 2, 25, -25);
        check("R3 +2.5/-2.5 accepted", {est, code}, {1'b1, exp_code(1, 2)});
        last_code = exp_code(1, 2);
        drive_pair(1, 2, 0, 40);
        check("R3 R7 +4% high rejected", {est, code}, {1'b0, last_code});

        // R4 alternating low-band periods never validate
        drive_pair(2, 0, 0, 0);
        check("R4 baseline", {est, code}, {1'b1, exp_code(2, 0)});
        last_code = exp_code(2, 0);
        lo_per = per_of(0, 0, 0);
        lo_alt = per_of(0, 1, 0);
        wait_cyc(SETTLE);
        check("R4 alternating bins", {est, code}, {1'b0, last_code});
        lo_alt = 0;

        // R8 timeout on a silent band, then recovery
        drive_pair(3, 3, 0, 0);
        check("R8 before silence", {est, code}, {1'b1, exp_code(3, 3)});
        last_code = exp_code(3, 3);
        hi_per = 0;
        wait_cyc(2 * per_of(0, 0, 0) + 200);
        check("R8 R5 silent band clears est", {est, code}, {1'b0, last_code});
        drive_pair(0, 3, 0, 0);
        check("R8 recovery", {est, code}, {1'b1, exp_code(0, 3)});

        // R9 very fast toggling (one-cycle pulses) is not classified
        lo_per = 2;
        wait_cyc(SETTLE);
        check("R9 R3 out-of-band fast wave", {4'd0, est}, 5'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule